// File: doc/BRIEF.md
# EDID I2C Read-Only Target

This block is an I2C target that hands a fixed 256-byte display-identification table to a bus controller over a two-wire display channel. It watches SCL and SDA as plain inputs and oversamples both on the system clock. It never drives a line high. Instead it asserts a pull-low request that the pad turns into an open-drain drive.

The only state a controller can change is an 8-bit byte pointer. The first data byte after a write-direction address reloads the pointer. Any later bytes in that write are acknowledged and thrown away, but each one still moves the pointer forward by one. Read transfers stream table bytes starting at the pointer, and the pointer wraps past the last entry back to the first.

A usual access writes the pointer, issues a repeated START with the read address, and then reads a burst.

Top module: `edid_i2c_target`

## Requirements
- R1: After reset the pointer is 0, no first-byte load is pending and `sda_pull` is 0. A read issued straight after reset returns table entry 0.
- R2: The target acknowledges (pulls SDA low in the ninth clock) an address byte whose upper 7 bits equal `DEV_ADDR` (default 0x50), with bit 0 = 0 for write and 1 for read. For any other address it leaves SDA released in that clock.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP returns the target to idle and leaves the pointer unchanged.
- R4: In a write transfer addressed to the target, the first data byte replaces the pointer.
- R5: Every data byte written to the target is acknowledged. Bytes after the first leave the table contents unchanged and each one adds 1 to the pointer.
- R6: A read returns entry[pointer] MSB first and then adds 1 to the pointer, once for each byte sent.
- R7: The pointer is 8 bits wide, so a burst read continues from entry 255 to entry 0.
- R8: A read transfer does not reload the pointer. A read with no pointer write before it continues from where the last access left off.
- R9: After a pointer write, a repeated START followed by the read address returns data starting at the new pointer.
- R10: When the controller does not acknowledge a read byte, the target releases SDA and stays released until the next START.
- R11: `sda_pull` changes only while the filtered SCL is low.
- R12: Each line passes through a 2-flop synchroniser and a 3-sample filter. A pulse of 2 system clocks or less, including one on SDA while SCL is high, is ignored.
- R13: Table entry i holds ((i*37 + 11) mod 256) XOR 0x3C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_pull | output | 1 | 1 = pull SDA low; 0 = release |

## Verification
A bus edge takes about six system clocks to reach the target's state: two synchroniser flops, three filter samples and one edge register. An ACK or data bit the target drives therefore appears that long after the SCL fall that caused it. The modelled controller holds every quarter bit for ten system clocks. This lets any response settle before the next SCL rise, and the bench reads SDA on a falling clock edge in the middle of the high phase. Pointer effects, such as loads, ignored writes and wrap, are observed only through the bytes that later reads return, so each check's result is due in the byte read that follows.

// File: rtl/edid_i2c_target.sv
module edid_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);

  localparam int PW = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK0, S_AACK, S_WBIT, S_WACK0, S_WACK, S_RBIT, S_RACK, S_RNEXT
  } st_t;

  function automatic logic [7:0] tbl_val(input logic [PW-1:0] i);
    tbl_val = (i * 8'd37 + 8'd11) ^ 8'h3C;
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_sy[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  st_t st;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [PW-1:0] ptr;
  logic first, rw;

  wire [7:0] rx_byte = {sh[6:0], sda_f};
  wire [7:0] rom_q = tbl_val(ptr);
  wire addr_hit = (sh[7:1] == DEV_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ptr <= '0;
      first <= 1'b0; rw <= 1'b0; sda_pull <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= '0; sda_pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_pull <= 1'b0;
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          sh <= rx_byte;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) st <= S_AACK0;
        end
        S_AACK0: if (scl_fall) begin
          if (addr_hit) begin
            sda_pull <= 1'b1;
            rw <= sh[0];
            first <= ~sh[0];
            st <= S_AACK;
          end else st <= S_IDLE;
        end
        S_AACK, S_RNEXT: if (scl_fall) begin
          cnt <= '0;
          if (st == S_RNEXT || rw) begin
            sh <= rom_q;
            sda_pull <= ~rom_q[7];
            ptr <= ptr + 1'b1;
            st <= S_RBIT;
          end else begin
            sda_pull <= 1'b0;
            st <= S_WBIT;
          end
        end
        S_WBIT: if (scl_rise) begin
          sh <= rx_byte;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            st <= S_WACK0;
            if (first) begin
              ptr <= rx_byte;
              first <= 1'b0;
            end else ptr <= ptr + 1'b1;
          end
        end
        S_WACK0: if (scl_fall) begin
          sda_pull <= 1'b1;
          st <= S_WACK;
        end
        S_WACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          cnt <= '0;
          st <= S_WBIT;
        end
        S_RBIT: if (scl_fall) begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            sda_pull <= 1'b0;
            st <= S_RACK;
          end else begin
            sh <= {sh[6:0], 1'b0};
            sda_pull <= ~sh[6];
          end
        end
        S_RACK: if (scl_rise) st <= sda_f ? S_IDLE : S_RNEXT;
        default: ;
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (ptr == '0) && !first && !sda_pull);

  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);

  a_r5_ptr_step_or_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || $past(first)));

  a_r2_miss_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AACK0 && scl_fall && !start_c && !stop_c && !addr_hit) |=> !sda_pull);

  a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && scl_rise && sda_f && !start_c && !stop_c) |=> !sda_pull);

endmodule

// File: tb/sim_edid_i2c_target.sv
module sim_edid_i2c_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  wire sda = sda_m & ~sda_pull;

  int errors = 0;
  int checks = 0;
  int viol = 0;
  logic prev_scl = 1'b1, prev_pull = 1'b0;

  always #4 clk = ~clk;

  edid_i2c_target u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .sda_pull(sda_pull));

  function automatic logic [7:0] tv(input logic [7:0] i);
    tv = (i * 8'd37 + 8'd11) ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && (sda_pull != prev_pull)) viol++;
    prev_scl <= scl;
    prev_pull <= sda_pull;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; w(Q);
    scl = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q);
    scl = 1'b1; w(Q);
    sda_m = 1'b1; w(2*Q);
  endtask

  task automatic put_bit(input logic b, input bit g);
    sda_m = b; w(Q);
    scl = 1'b1; w(Q);
    if (g && b) begin
      sda_m = 1'b0; w(2);
      sda_m = 1'b1; w(Q-2);
    end else w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; w(Q);
    scl = 1'b1; w(Q);
    @(negedge clk) b = sda;
    w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, input bit g, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], g);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!ack, 1'b0);
  endtask

  task automatic t_reset();
    bit a; logic [7:0] d;
    check(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);
    bus_start(); put_byte(8'hA1, 0, a);
    check(a, "R2 read address acked", a, 1);
    get_byte(d, 0);
    check(d == tv(0), "R1 R13 first read gives entry 0", d, tv(0));
    bus_stop();
  endtask

  task automatic t_addr();
    bit a; logic [7:0] d;
    bus_start(); put_byte(8'hA2, 0, a);
    check(!a, "R2 foreign address not acked", a, 0);
    bus_stop();
    bus_start(); put_byte(8'hA0, 0, a);
    check(a, "R2 write address acked", a, 1);
    bus_stop();
    bus_start(); put_byte(8'hA1, 0, a);
    get_byte(d, 0);
    check(d == tv(1), "R3 R8 stop keeps pointer, read continues", d, tv(1));
    bus_stop();
  endtask

  task automatic t_ptr_restart();
    bit a; logic [7:0] d, p;
    p = 8'($urandom % 200);
    bus_start(); put_byte(8'hA0, 0, a); put_byte(p, 0, a);
    check(a, "R4 pointer byte acked", a, 1);
    bus_rstart(); put_byte(8'hA1, 0, a);
    for (int k = 0; k < 3; k++) begin
      get_byte(d, k != 2);
      check(d == tv(p + 8'(k)), "R9 R6 burst after restart", d, tv(p + 8'(k)));
    end
    bus_stop();
    bus_start(); put_byte(8'hA1, 0, a); get_byte(d, 0);
    check(d == tv(p + 8'd3), "R8 read resumes from pointer", d, tv(p + 8'd3));
    bus_stop();
  endtask

  task automatic t_ignored();
    bit a; logic [7:0] d;
    bus_start(); put_byte(8'hA0, 0, a); put_byte(8'hFD, 0, a);
    put_byte(8'h11, 0, a); check(a, "R5 extra byte acked", a, 1);
    put_byte(8'h22, 0, a); put_byte(8'h33, 0, a);
    check(a, "R5 last extra byte acked", a, 1);
    bus_stop();
    bus_start(); put_byte(8'hA1, 0, a); get_byte(d, 0);
    check(d == tv(0), "R5 ignored writes advance pointer", d, tv(0));
    bus_stop();
  endtask

  task automatic t_wrap();
    bit a; logic [7:0] d, e;
    bus_start(); put_byte(8'hA0, 0, a); put_byte(8'hFC, 0, a);
    bus_rstart(); put_byte(8'hA1, 0, a);
    for (int k = 0; k < 5; k++) begin
      get_byte(d, k != 4);
      e = tv(8'hFC + 8'(k));
      check(d == e, "R7 R5 wrap burst, table unchanged", d, e);
    end
    bus_stop();
  endtask

  task automatic t_nack();
    bit a; logic [7:0] d; logic b; int low = 0;
    bus_start(); put_byte(8'hA1, 0, a); get_byte(d, 0);
    check(d == tv(1), "R6 read after wrap", d, tv(1));
    for (int k = 0; k < 9; k++) begin
      get_bit(b);
      if (!b) low++;
    end
    check(low == 0, "R10 released after nack", low, 0);
    bus_stop();
  endtask

  task automatic t_glitch();
    bit a; logic [7:0] d;
    bus_start(); put_byte(8'hA0, 0, a); put_byte(8'hFF, 1, a);
    check(a, "R12 glitched byte acked", a, 1);
    bus_rstart(); put_byte(8'hA1, 0, a); get_byte(d, 0);
    check(d == tv(8'hFF), "R12 glitches ignored", d, tv(8'hFF));
    bus_stop();
  endtask

  initial begin
    w(10);
    rst_n = 1'b1;
    w(10);
    t_reset();
    t_addr();
    t_ptr_restart();
    t_ignored();
    t_wrap();
    t_nack();
    t_glitch();
    check(viol == 0, "R11 sda_pull steady while SCL high", viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    w(150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule